// File: doc/BRIEF.md
# Free-Running 64-bit Cycle Counter with Torn-Read Detection

The block holds a 64-bit counter that advances once per clock while enabled, and presents it to a 32-bit register bus as two halves plus a control/status word. A full value cannot be fetched in one access, so the counter keeps running between the two half reads. The block does not freeze either half. Instead it watches the access sequence and reports in the status word whether the last low-then-high pair describes a single instant.

Software reads the low half, then the high half, then the control word. It keeps the pair only when the status bit is set, and otherwise repeats the three reads. A pair is marked torn in two cases: an interrupt or exception is taken on the processor side between the two reads, or a carry moves into the high half after the low half was sampled.

Register access is one request per cycle, presented with `acc_valid`. Requests are never back-pressured: every request is accepted in the cycle it is presented. A read returns its data with `rsp_valid` exactly one cycle later. A write returns no response.

Top module: `tick64_snap`

## Requirements
- R1: After reset the count is zero, counting is disabled, the status bit reads 0 and `rsp_valid` is low.
- R2: Writing the control word sets the enable from data bit 0. While enable is 1 the count rises by exactly one per clock, and while it is 0 the count holds. A write takes effect from the following clock.
- R3: A read request returns `rsp_valid` high for one cycle, in the cycle after the request. A write or idle cycle leaves `rsp_valid` low. Every request is accepted, including back-to-back requests.
- R4: The control word is at `BASE_ADDR`, the low half at `BASE_ADDR+1` and the high half at `BASE_ADDR+2`. A read of any other address returns zero.
- R5: A control read returns the enable in bit 0 and the status in the top bit (bit `HALF_W-1`, bit 31 at the default width). All bits between them read 0.
- R6: The status reads 1 when a low read was followed directly by a high read with no disruption in between. It keeps reading 1 across repeated control reads until the next low read.
- R7: If `irq_taken` is high in any cycle after the low read and before the cycle of the high read, the status reads 0. The flag has no effect in the cycle of either read.
- R8: If a carry enters the high half at or after the clock edge that captures the low read, but before the edge that captures the high read, the status reads 0. A carry at the high-read edge itself leaves the pair consistent.
- R9: A high read without a pending low read, or a control read or unmapped read between the low and high reads, ends the sequence with the status at 0.
- R10: Writes to the low or high half address are ignored and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Register request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | HALF_W | Write data |
| irq_taken | input | 1 | Interrupt or exception taken on the processor side |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | HALF_W | Read data |

## Verification
The bench builds the block with `HALF_W` = 8, which makes a 16-bit counter. With that width a carry into the high half comes every 256 enabled cycles, so the carry cases can be placed within a short run: a carry on the edge that captures the low read, a carry during idle cycles between the reads, and a carry on the edge that captures the high read. At the default width of 32 a carry would need billions of cycles. At the reduced width the status bit sits at bit 7, and every ordering and interrupt case is checked there.

// File: rtl/tick64_pkg.sv
`timescale 1ns/1ps
package tick64_pkg;

  // read-sequence tracker states
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_LOW  = 2'd1,
    TRK_DONE = 2'd2
  } trk_state_t;

  // decoded register target of an access
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_t;

endpackage

// File: rtl/tick64_core.sv
`timescale 1ns/1ps
module tick64_core #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_wbit,
  output logic              en_q,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              hi_inc
);
  localparam int NHALF = 2;
  localparam int CNT_W = NHALF * HALF_W;

  logic [NHALF-1:0] carry;

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (ctrl_wr) en_q <= ctrl_wbit;
  end

  assign carry[0] = en_q;

  // one counter register per half, chained by a ripple carry
  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic [HALF_W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (rst)           q_r <= '0;
      else if (carry[g]) q_r <= q_r + 1'b1;
    end
    if (g + 1 < NHALF) begin : g_chain
      assign carry[g+1] = carry[g] & (&q_r);
    end
  end

  assign cnt_lo = g_half[0].q_r;
  assign cnt_hi = g_half[1].q_r;
  assign hi_inc = carry[NHALF-1];

  logic [CNT_W-1:0] cnt_all;
  assign cnt_all = {cnt_hi, cnt_lo};

  // R2
  incr_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> cnt_all == $past(cnt_all) + 1'b1);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(cnt_all));

  // R8
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    hi_inc |=> cnt_hi == $past(cnt_hi) + 1'b1);

endmodule

// File: rtl/tick64_tracker.sv
`timescale 1ns/1ps
module tick64_tracker
  import tick64_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_stb,
  input  reg_sel_t sel,
  input  logic     irq_taken,
  input  logic     hi_inc,
  output logic     status
);
  trk_state_t st_q;
  logic       disrupt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= TRK_IDLE;
      disrupt_q <= 1'b0;
    end else if (rd_stb) begin
      unique case (sel)
        SEL_LO: begin
          st_q      <= TRK_LOW;
          disrupt_q <= hi_inc;   // carry on the capture edge of low
        end
        SEL_HI: begin
          st_q <= (st_q == TRK_LOW) ? TRK_DONE : TRK_IDLE;
        end
        SEL_CTRL: begin
          if (st_q == TRK_LOW) st_q <= TRK_IDLE;
        end
        default: begin
          if (st_q == TRK_LOW) st_q <= TRK_IDLE;
        end
      endcase
    end else if (st_q == TRK_LOW) begin
      disrupt_q <= disrupt_q | irq_taken | hi_inc;
    end
  end

  assign status = (st_q == TRK_DONE) && !disrupt_q;

  // R6
  done_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == TRK_DONE && $past(st_q) != TRK_DONE) |-> $past(st_q) == TRK_LOW);

  // R7
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == TRK_LOW && !rd_stb && irq_taken) |=> disrupt_q);

  // R8
  carry_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == TRK_LOW && !rd_stb && hi_inc) |=> disrupt_q);

  // R8
  carry_at_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel == SEL_LO && hi_inc) |=> (disrupt_q && st_q == TRK_LOW));

endmodule

// File: rtl/tick64_regif.sv
`timescale 1ns/1ps
module tick64_regif
  import tick64_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          HALF_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h103
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic [HALF_W-1:0] cnt_hi,
  input  logic              en_q,
  input  logic              status,
  output reg_sel_t          sel,
  output logic              rd_stb,
  output logic              ctrl_wr,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(BASE_ADDR + 2);
  localparam int                STAT_B = HALF_W - 1;

  logic [HALF_W-1:0] ctrl_word;
  logic [HALF_W-1:0] rd_mux;

  always_comb begin
    if (acc_addr == A_CTRL)    sel = SEL_CTRL;
    else if (acc_addr == A_LO) sel = SEL_LO;
    else if (acc_addr == A_HI) sel = SEL_HI;
    else                       sel = SEL_NONE;
  end

  assign rd_stb  = acc_valid && !acc_write;
  assign ctrl_wr = acc_valid && acc_write && (sel == SEL_CTRL);

  always_comb begin
    ctrl_word         = '0;
    ctrl_word[0]      = en_q;
    ctrl_word[STAT_B] = status;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_LO:   rd_mux = cnt_lo;
      SEL_HI:   rd_mux = cnt_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_stb;
      rsp_data  <= rd_stb ? rd_mux : '0;
    end
  end

  // R3
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc_valid && !acc_write));

  // R5
  ctrl_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(sel == SEL_CTRL)) |-> rsp_data[STAT_B-1:1] == '0);

  // R4
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(sel == SEL_NONE)) |-> rsp_data == '0);

endmodule

// File: rtl/tick64_snap.sv
`timescale 1ns/1ps
module tick64_snap
  import tick64_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          HALF_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h103
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [HALF_W-1:0] acc_wdata,
  input  logic              irq_taken,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data
);
  reg_sel_t          sel;
  logic              rd_stb;
  logic              ctrl_wr;
  logic              en_q;
  logic              hi_inc;
  logic              status;
  logic [HALF_W-1:0] cnt_lo;
  logic [HALF_W-1:0] cnt_hi;
  logic              wdata_unused;

  // only bit 0 of a control write carries meaning
  assign wdata_unused = ^acc_wdata[HALF_W-1:1];

  tick64_regif #(
    .ADDR_W   (ADDR_W),
    .HALF_W   (HALF_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_regif (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .en_q     (en_q),
    .status   (status),
    .sel      (sel),
    .rd_stb   (rd_stb),
    .ctrl_wr  (ctrl_wr),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  tick64_core #(
    .HALF_W(HALF_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .ctrl_wbit(acc_wdata[0]),
    .en_q     (en_q),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .hi_inc   (hi_inc)
  );

  tick64_tracker u_trk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .sel      (sel),
    .irq_taken(irq_taken),
    .hi_inc   (hi_inc),
    .status   (status)
  );

  // R10
  lohi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && sel != SEL_CTRL && !en_q) |=> $stable({cnt_hi, cnt_lo}));

endmodule

// File: tb/tick64_snap_tb.sv
`timescale 1ns/1ps
module tick64_snap_tb_top;
  localparam int          ADDR_W = 12;
  localparam int          HALF_W = 8;
  localparam logic [31:0] BASE   = 32'h103;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              acc_valid = 1'b0;
  logic              acc_write = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [HALF_W-1:0] acc_wdata = '0;
  logic              irq_taken = 1'b0;
  logic              rsp_valid;
  logic [HALF_W-1:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tick64_snap #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .irq_taken(irq_taken),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // reference count built from R1, R2 and R10
  logic [2*HALF_W-1:0] mcnt;
  logic                men;
  always @(posedge clk) begin
    if (rst) begin
      mcnt <= '0;
      men  <= 1'b0;
    end else begin
      if (men) mcnt <= mcnt + 1'b1;
      if (acc_valid && acc_write && acc_addr == ADDR_W'(BASE)) men <= acc_wdata[0];
    end
  end

  typedef struct packed {
    logic [1:0] op;    // 0 idle, 1 read, 2 write
    logic [1:0] off;   // 0 ctrl, 1 low, 2 high, 3 unmapped
    logic [7:0] wd;
    logic       irq;
    logic [1:0] kind;  // 0 none, 1 exact, 2 model low, 3 model high
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h00, 4'd1},  // R1 ctrl after reset
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd1},  // R1 low zero
    '{2'd1, 2'd2, 8'h00, 1'b0, 2'd3, 8'h00, 4'd1},  // R1 high zero
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h80, 4'd6},  // R6 clean pair
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h80, 4'd6},  // R6 status persists
    '{2'd2, 2'd0, 8'h01, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 enable
    '{2'd0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd3},
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h81, 4'd5},  // R5 enable and status
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd2},  // R2 counting
    '{2'd0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd3},
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd2},  // R2 counting
    '{2'd0, 2'd0, 8'h00, 1'b1, 2'd0, 8'h00, 4'd7},  // R7 irq between
    '{2'd1, 2'd2, 8'h00, 1'b0, 2'd3, 8'h00, 4'd2},
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h01, 4'd7},  // R7 torn
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd2},
    '{2'd1, 2'd2, 8'h00, 1'b1, 2'd3, 8'h00, 4'd7},  // R7 irq on high cycle
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h81, 4'd7},  // R7 not torn
    '{2'd1, 2'd2, 8'h00, 1'b0, 2'd3, 8'h00, 4'd9},  // R9 high alone
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h01, 4'd9},
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd9},
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h01, 4'd9},  // R9 ctrl in between
    '{2'd1, 2'd2, 8'h00, 1'b0, 2'd3, 8'h00, 4'd9},
    '{2'd1, 2'd0, 8'h00, 1'b0, 2'd1, 8'h01, 4'd9},  // R9 sequence broken
    '{2'd1, 2'd3, 8'h00, 1'b0, 2'd1, 8'h00, 4'd4},  // R4 unmapped reads 0
    '{2'd2, 2'd1, 8'h55, 1'b0, 2'd0, 8'h00, 4'd10}, // R10 write low
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd10},
    '{2'd2, 2'd2, 8'hAA, 1'b0, 2'd0, 8'h00, 4'd10}, // R10 write high
    '{2'd1, 2'd2, 8'h00, 1'b0, 2'd3, 8'h00, 4'd10},
    '{2'd2, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd2},  // R2 disable
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd2},
    '{2'd0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 4'd3},
    '{2'd1, 2'd1, 8'h00, 1'b0, 2'd2, 8'h00, 4'd2}   // R2 held
  };

  task automatic chk(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one access cycle, driven and checked at falling edges
  task automatic step(input vec_t v);
    logic [HALF_W-1:0] exp_v;
    acc_valid = (v.op != 2'd0);
    acc_write = (v.op == 2'd2);
    case (v.off)
      2'd0:    acc_addr = ADDR_W'(BASE);
      2'd1:    acc_addr = ADDR_W'(BASE + 1);
      2'd2:    acc_addr = ADDR_W'(BASE + 2);
      default: acc_addr = ADDR_W'(BASE + 5);
    endcase
    acc_wdata = v.wd;
    irq_taken = v.irq;
    case (v.kind)
      2'd2:    exp_v = mcnt[HALF_W-1:0];
      2'd3:    exp_v = mcnt[2*HALF_W-1:HALF_W];
      default: exp_v = v.exp;
    endcase
    @(negedge clk);
    // R3 response presence
    chk(rsp_valid == (v.op == 2'd1), 3, int'(rsp_valid), int'(v.op == 2'd1));
    if (v.op == 2'd1 && v.kind != 2'd0)
      chk(rsp_data == exp_v, int'(v.req), int'(rsp_data), int'(exp_v));
    acc_valid = 1'b0;
    acc_write = 1'b0;
    irq_taken = 1'b0;
  endtask

  function automatic vec_t mk(input logic [1:0] op, input logic [1:0] off,
                              input logic [7:0] wd, input logic [1:0] kind,
                              input logic [7:0] exp, input logic [3:0] req);
    vec_t v;
    v.op = op; v.off = off; v.wd = wd; v.irq = 1'b0;
    v.kind = kind; v.exp = exp; v.req = req;
    return v;
  endfunction

  task automatic wait_low(input logic [7:0] target);
    while (mcnt[HALF_W-1:0] != target) step(mk(2'd0, 2'd0, 8'h00, 2'd0, 8'h00, 4'd3));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 outputs quiet out of reset
    chk(rsp_valid == 1'b0, 1, int'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R8 carry on the capture edge of the low read
    step(mk(2'd2, 2'd0, 8'h01, 2'd0, 8'h00, 4'd2));
    wait_low(8'hFF);
    step(mk(2'd1, 2'd1, 8'h00, 2'd2, 8'h00, 4'd8));
    step(mk(2'd1, 2'd2, 8'h00, 2'd3, 8'h00, 4'd8));
    step(mk(2'd1, 2'd0, 8'h00, 2'd1, 8'h01, 4'd8));

    // R8 carry on the capture edge of the high read: consistent
    wait_low(8'hFE);
    step(mk(2'd1, 2'd1, 8'h00, 2'd2, 8'h00, 4'd8));
    step(mk(2'd1, 2'd2, 8'h00, 2'd3, 8'h00, 4'd8));
    step(mk(2'd1, 2'd0, 8'h00, 2'd1, 8'h81, 4'd8));

    // R8 carry during idle cycles between the reads
    wait_low(8'hFC);
    step(mk(2'd1, 2'd1, 8'h00, 2'd2, 8'h00, 4'd8));
    for (int k = 0; k < 4; k++) step(mk(2'd0, 2'd0, 8'h00, 2'd0, 8'h00, 4'd3));
    step(mk(2'd1, 2'd2, 8'h00, 2'd3, 8'h00, 4'd8));
    step(mk(2'd1, 2'd0, 8'h00, 2'd1, 8'h01, 4'd8));

    // R1 reset in the middle of counting
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(mk(2'd1, 2'd0, 8'h00, 2'd1, 8'h00, 4'd1));
    step(mk(2'd1, 2'd1, 8'h00, 2'd1, 8'h00, 4'd1));
    step(mk(2'd1, 2'd2, 8'h00, 2'd1, 8'h00, 4'd1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule